// File: doc/BRIEF.md
# OLED Panel Power-Up Command Sequencer

This block brings a small monochrome OLED panel controller out of reset and configures it. After its own reset it drives a panel reset pulse, then waits for a settle time. It then plays an ordered set of configuration commands toward an external I2C master through a byte-stream handshake. Every command byte and every argument byte leaves as its own two-byte write: a command-type control byte, then the byte itself. The first byte of each write is flagged with a start-of-transaction marker.

Argument bytes are packed from static configuration inputs: panel height, contrast, clock divider and frequency, precharge phases, COM wiring options, VCOMH level, charge-pump need and an optional four-entry grey-level table. Some command groups are sent or skipped depending on flags. Once the last command is accepted, the block pulses a done output. After that, a request input can switch the panel on or off with a single command.

Top module: `oled_init_seq`

## Requirements
- R1: Each command or argument byte is carried by a two-byte write: first 0x80 with `outStart` high, then the byte itself with `outStart` low.
- R2: During reset and for `RST_ACTIVE_CYC` cycles after reset release, `panelRstOut` is high. It then stays low for `RST_SETTLE_CYC` cycles before `outValid` first rises. No byte is offered while `panelRstOut` is high.
- R3: The stream opens with 0x81 and the contrast value, then optionally 0xA1 (see R4), then 0xC0 with bit 3 set to `cfgComInv`. Next come 0xA8 with height minus one, 0xD3 with the COM offset, and 0xD5 with ((divider-1) mod 16) in bits 3:0 and the frequency code in bits 7:4.
- R4: The segment-remap byte 0xA1 is sent only when `cfgSegRemap` is 1.
- R5: The pair 0xD8 plus argument follows the clock command only when area colour or low power is enabled. The argument is 0x30 for area colour, ORed with 0x05 for low power.
- R6: Next come four pairs. Precharge is 0xD9 with phase 1 in bits 3:0 and phase 2 in bits 7:4. COM pins is 0xDA with 0x02, bit 4 set when `cfgComSeq` is 0, and bit 5 equal to `cfgComLrRemap`. VCOMH is 0xDB with the VCOMH level. Charge pump is 0x8D with 0x10, ORed with 0x04 when `cfgPumpNeed` is 1.
- R7: When `cfgLutEn` is 1, 0x91 is sent next, followed by the four table entries. Entry 0 comes from `cfgLut[7:0]` and is sent first; entry 3 comes from `cfgLut[31:24]` and is sent last.
- R8: The stream ends with 0x20, 0x00 and 0xAF. `initDone` is high for exactly one cycle, in the cycle after the final 0xAF byte is accepted.
- R9: While a table entry outside 31..63 is offered as the byte of its write, `lutWarn` is high. The byte is sent unchanged.
- R10: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outStart` hold their values into the next cycle.
- R11: After `initDone`, a `pwrReq` pulse sends one write: 0xAF if `pwrOn` is 1, or 0xAE if it is 0. This does not pulse `initDone`.
- R12: A `pwrReq` raised before `initDone` has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgHeight | input | 8 | Panel height in rows |
| cfgContrast | input | 8 | Contrast value |
| cfgComOffset | input | 8 | COM display offset |
| cfgClkDiv | input | 5 | Display clock divider, 1..16 |
| cfgClkFrq | input | 4 | Oscillator frequency code |
| cfgPre1 | input | 4 | Precharge phase 1 |
| cfgPre2 | input | 4 | Precharge phase 2 |
| cfgVcomh | input | 8 | VCOMH deselect level |
| cfgSegRemap | input | 1 | Send segment remap |
| cfgComInv | input | 1 | Reverse COM scan direction |
| cfgComSeq | input | 1 | Sequential COM pin layout |
| cfgComLrRemap | input | 1 | Left/right COM remap |
| cfgPumpNeed | input | 1 | Enable internal charge pump |
| cfgAreaColor | input | 1 | Area colour mode |
| cfgLowPower | input | 1 | Low-power display mode |
| cfgLutEn | input | 1 | Send grey-level table |
| cfgLut | input | 32 | Four table entries, entry 0 in bits 7:0 |
| pwrReq | input | 1 | Runtime on/off request pulse |
| pwrOn | input | 1 | Requested state, 1 for on |
| outReady | input | 1 | Downstream accepts the byte |
| outValid | output | 1 | Byte offered |
| outData | output | 8 | Offered byte |
| outStart | output | 1 | First byte of a write |
| panelRstOut | output | 1 | Active-high panel reset |
| lutWarn | output | 1 | Offered table entry is out of range |
| initDone | output | 1 | One-cycle end-of-configuration pulse |

## Verification
The assertions check the handshake on every cycle:
- the held byte under back-pressure;
- a control prefix always carrying 0x80 and always followed by a payload;
- no traffic during the panel reset pulse;
- the warning appearing only on payload bytes;
- the done pulse following acceptance of a display-on byte and lasting one cycle.

Only the bench scenarios can show the contents and order of the command stream under different flag sets, and the argument packing. The same holds for the reset pulse and settle durations, and for an early request being dropped.

// File: rtl/oled_seq_pkg.sv
`timescale 1ns/1ps
package oled_seq_pkg;

  localparam int BYTE_W      = 8;
  localparam int LUT_ENTRIES = 4;
  localparam logic [BYTE_W-1:0] CMD_PREFIX = 8'h80;
  localparam logic [BYTE_W-1:0] LUT_LO     = 8'd31;
  localparam logic [BYTE_W-1:0] LUT_HI     = 8'd63;

  typedef enum logic [4:0] {
    S_CONTRAST_C, S_CONTRAST_A, S_REMAP, S_COMDIR,
    S_MUX_C, S_MUX_A, S_OFS_C, S_OFS_A, S_CLK_C, S_CLK_A,
    S_AREA_C, S_AREA_A, S_PRE_C, S_PRE_A, S_PINS_C, S_PINS_A,
    S_VCOMH_C, S_VCOMH_A, S_PUMP_C, S_PUMP_A,
    S_LUT_C, S_LUT_0, S_LUT_1, S_LUT_2, S_LUT_3,
    S_MODE_C, S_MODE_A, S_DISP_ON, S_RUNTIME
  } seqStep_e;

  typedef struct packed {
    seqStep_e step;
    logic     latchPwr;
    logic     pwrVal;
  } seqCtrl_t;

  typedef struct packed {
    logic [7:0] height;
    logic [7:0] contrast;
    logic [7:0] comOffset;
    logic [4:0] clkDiv;
    logic [3:0] clkFrq;
    logic [3:0] pre1;
    logic [3:0] pre2;
    logic [7:0] vcomh;
    logic       segRemap;
    logic       comInv;
    logic       comSeq;
    logic       comLrRemap;
    logic       pumpNeed;
    logic       areaColor;
    logic       lowPower;
    logic       lutEn;
    logic [LUT_ENTRIES*BYTE_W-1:0] lut;
  } panelCfg_t;

endpackage

// File: rtl/oled_seq_datapath.sv
`timescale 1ns/1ps
module oled_seq_datapath
  import oled_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  panelCfg_t         cfg,
  input  seqCtrl_t          ctrl,
  output logic [BYTE_W-1:0] stepByte,
  output logic              stepSkip,
  output logic              stepWarn
);

  logic [BYTE_W-1:0] lutEntry [LUT_ENTRIES];
  logic [LUT_ENTRIES-1:0] lutBad;
  logic pwrOnQ;
  logic [4:0] clkDivM1;

  generate
    for (genvar i = 0; i < LUT_ENTRIES; i++) begin : g_lut
      assign lutEntry[i] = cfg.lut[i*BYTE_W +: BYTE_W];
      assign lutBad[i]   = (lutEntry[i] < LUT_LO) || (lutEntry[i] > LUT_HI);
    end
  endgenerate

  // Requested panel state for the runtime command, captured on the request
  always_ff @(posedge clk) begin
    if (!rstN)              pwrOnQ <= 1'b1;
    else if (ctrl.latchPwr) pwrOnQ <= ctrl.pwrVal;
  end

  assign clkDivM1 = cfg.clkDiv - 5'd1;

  always_comb begin
    stepByte = '0;
    stepSkip = 1'b0;
    stepWarn = 1'b0;
    case (ctrl.step)
      S_CONTRAST_C: stepByte = 8'h81;
      S_CONTRAST_A: stepByte = cfg.contrast;
      S_REMAP:      begin stepByte = 8'hA1; stepSkip = !cfg.segRemap; end
      S_COMDIR:     stepByte = 8'hC0 | {4'b0, cfg.comInv, 3'b0};
      S_MUX_C:      stepByte = 8'hA8;
      S_MUX_A:      stepByte = cfg.height - 8'd1;
      S_OFS_C:      stepByte = 8'hD3;
      S_OFS_A:      stepByte = cfg.comOffset;
      S_CLK_C:      stepByte = 8'hD5;
      S_CLK_A:      stepByte = {cfg.clkFrq, clkDivM1[3:0]};
      S_AREA_C:     begin stepByte = 8'hD8; stepSkip = !(cfg.areaColor || cfg.lowPower); end
      S_AREA_A:     begin
        stepByte = (cfg.areaColor ? 8'h30 : 8'h00) | (cfg.lowPower ? 8'h05 : 8'h00);
        stepSkip = !(cfg.areaColor || cfg.lowPower);
      end
      S_PRE_C:      stepByte = 8'hD9;
      S_PRE_A:      stepByte = {cfg.pre2, cfg.pre1};
      S_PINS_C:     stepByte = 8'hDA;
      S_PINS_A:     stepByte = {2'b00, cfg.comLrRemap, !cfg.comSeq, 4'h2};
      S_VCOMH_C:    stepByte = 8'hDB;
      S_VCOMH_A:    stepByte = cfg.vcomh;
      S_PUMP_C:     stepByte = 8'h8D;
      S_PUMP_A:     stepByte = 8'h10 | (cfg.pumpNeed ? 8'h04 : 8'h00);
      S_LUT_C:      begin stepByte = 8'h91; stepSkip = !cfg.lutEn; end
      S_LUT_0:      begin stepByte = lutEntry[0]; stepSkip = !cfg.lutEn; stepWarn = lutBad[0]; end
      S_LUT_1:      begin stepByte = lutEntry[1]; stepSkip = !cfg.lutEn; stepWarn = lutBad[1]; end
      S_LUT_2:      begin stepByte = lutEntry[2]; stepSkip = !cfg.lutEn; stepWarn = lutBad[2]; end
      S_LUT_3:      begin stepByte = lutEntry[3]; stepSkip = !cfg.lutEn; stepWarn = lutBad[3]; end
      S_MODE_C:     stepByte = 8'h20;
      S_MODE_A:     stepByte = 8'h00;
      S_DISP_ON:    stepByte = 8'hAF;
      S_RUNTIME:    stepByte = pwrOnQ ? 8'hAF : 8'hAE;
      default:      stepSkip = 1'b1;
    endcase
  end

endmodule

// File: rtl/oled_seq_ctrl.sv
`timescale 1ns/1ps
module oled_seq_ctrl
  import oled_seq_pkg::*;
#(
  parameter bit USE_PANEL_RESET = 1'b1,
  parameter int RST_ACTIVE_CYC  = 1000,
  parameter int RST_SETTLE_CYC  = 1000
)(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stepSkip,
  input  logic     outReady,
  input  logic     pwrReq,
  input  logic     pwrOn,
  output seqCtrl_t ctrl,
  output logic     outValid,
  output logic     outStart,
  output logic     panelRstOut,
  output logic     initDone
);

  localparam int CNT_MAX = (RST_ACTIVE_CYC > RST_SETTLE_CYC) ? RST_ACTIVE_CYC : RST_SETTLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {ST_RST_ACT, ST_RST_SET, ST_SEND, ST_IDLE} seqState_e;
  localparam seqState_e BOOT_STATE = USE_PANEL_RESET ? ST_RST_ACT : ST_SEND;

  seqState_e state;
  seqStep_e  step;
  logic      phase;      // 0: control prefix, 1: payload
  logic      timerHit;
  logic      accept;

  generate
    if (USE_PANEL_RESET) begin : g_rst_timer
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rstN) cnt <= '0;
        else if (state == ST_RST_ACT || state == ST_RST_SET)
          cnt <= timerHit ? '0 : cnt + 1'b1;
        else cnt <= '0;
      end
      assign timerHit = (state == ST_RST_ACT) ? (cnt == CNT_W'(RST_ACTIVE_CYC - 1))
                                              : (cnt == CNT_W'(RST_SETTLE_CYC - 1));
    end else begin : g_no_timer
      assign timerHit = 1'b1;
    end
  endgenerate

  assign outValid    = (state == ST_SEND) && !stepSkip;
  assign outStart    = outValid && !phase;
  assign panelRstOut = (state == ST_RST_ACT);
  assign accept      = outValid && outReady;

  assign ctrl.step     = step;
  assign ctrl.latchPwr = (state == ST_IDLE) && pwrReq;
  assign ctrl.pwrVal   = pwrOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= BOOT_STATE;
      step     <= S_CONTRAST_C;
      phase    <= 1'b0;
      initDone <= 1'b0;
    end else begin
      initDone <= 1'b0;
      case (state)
        ST_RST_ACT: if (timerHit) state <= ST_RST_SET;
        ST_RST_SET: if (timerHit) state <= ST_SEND;
        ST_SEND: begin
          if (stepSkip) begin
            step <= seqStep_e'(step + 5'd1);
          end else if (accept) begin
            if (!phase) begin
              phase <= 1'b1;
            end else begin
              phase <= 1'b0;
              if (step == S_DISP_ON) begin
                state    <= ST_IDLE;
                initDone <= 1'b1;
              end else if (step == S_RUNTIME) begin
                state <= ST_IDLE;
              end else begin
                step <= seqStep_e'(step + 5'd1);
              end
            end
          end
        end
        ST_IDLE: if (pwrReq) begin
          step  <= S_RUNTIME;
          phase <= 1'b0;
          state <= ST_SEND;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/oled_init_seq.sv
`timescale 1ns/1ps
module oled_init_seq
  import oled_seq_pkg::*;
#(
  parameter bit USE_PANEL_RESET = 1'b1,
  parameter int RST_ACTIVE_CYC  = 1000,
  parameter int RST_SETTLE_CYC  = 1000
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  cfgHeight,
  input  logic [7:0]  cfgContrast,
  input  logic [7:0]  cfgComOffset,
  input  logic [4:0]  cfgClkDiv,
  input  logic [3:0]  cfgClkFrq,
  input  logic [3:0]  cfgPre1,
  input  logic [3:0]  cfgPre2,
  input  logic [7:0]  cfgVcomh,
  input  logic        cfgSegRemap,
  input  logic        cfgComInv,
  input  logic        cfgComSeq,
  input  logic        cfgComLrRemap,
  input  logic        cfgPumpNeed,
  input  logic        cfgAreaColor,
  input  logic        cfgLowPower,
  input  logic        cfgLutEn,
  input  logic [31:0] cfgLut,
  input  logic        pwrReq,
  input  logic        pwrOn,
  input  logic        outReady,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        outStart,
  output logic        panelRstOut,
  output logic        lutWarn,
  output logic        initDone
);

  panelCfg_t         cfg;
  seqCtrl_t          ctrl;
  logic [BYTE_W-1:0] stepByte;
  logic              stepSkip;
  logic              stepWarn;

  assign cfg = '{height: cfgHeight, contrast: cfgContrast, comOffset: cfgComOffset,
                 clkDiv: cfgClkDiv, clkFrq: cfgClkFrq, pre1: cfgPre1, pre2: cfgPre2,
                 vcomh: cfgVcomh, segRemap: cfgSegRemap, comInv: cfgComInv,
                 comSeq: cfgComSeq, comLrRemap: cfgComLrRemap, pumpNeed: cfgPumpNeed,
                 areaColor: cfgAreaColor, lowPower: cfgLowPower, lutEn: cfgLutEn,
                 lut: cfgLut};

  oled_seq_ctrl #(
    .USE_PANEL_RESET(USE_PANEL_RESET),
    .RST_ACTIVE_CYC (RST_ACTIVE_CYC),
    .RST_SETTLE_CYC (RST_SETTLE_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .stepSkip(stepSkip), .outReady(outReady),
    .pwrReq(pwrReq), .pwrOn(pwrOn), .ctrl(ctrl), .outValid(outValid),
    .outStart(outStart), .panelRstOut(panelRstOut), .initDone(initDone)
  );

  oled_seq_datapath dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .ctrl(ctrl),
    .stepByte(stepByte), .stepSkip(stepSkip), .stepWarn(stepWarn)
  );

  assign outData = outStart ? CMD_PREFIX : stepByte;
  assign lutWarn = stepWarn && outValid && !outStart;

endmodule

// File: rtl/oled_seq_checker.sv
`timescale 1ns/1ps
module oled_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       outStart,
  input logic       panelRstOut,
  input logic       lutWarn,
  input logic       initDone
);

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outStart)); // R10

  AST_PREFIX_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outStart |-> outData == 8'h80); // R1

  AST_PREFIX_THEN_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outStart |=> outValid && !outStart); // R1

  AST_QUIET_IN_PANEL_RESET: assert property (@(posedge clk) disable iff (!rstN)
    panelRstOut |-> !outValid); // R2

  AST_WARN_ON_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    lutWarn |-> outValid && !outStart); // R9

  AST_DONE_AFTER_ON: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> $past(outValid && outReady && !outStart && outData == 8'hAF)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> !initDone); // R8

endmodule

bind oled_init_seq oled_seq_checker chk_i (.*);

// File: tb/oled_init_seq_tb.sv
`timescale 1ns/1ps
module oled_init_seq_tb_top;

  localparam int ACT = 40;
  localparam int SET = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgHeight = 8'd16, cfgContrast = 8'd127, cfgComOffset = 8'd0, cfgVcomh = 8'h20;
  logic [4:0] cfgClkDiv = 5'd1;
  logic [3:0] cfgClkFrq = 4'd8, cfgPre1 = 4'd2, cfgPre2 = 4'd2;
  logic cfgSegRemap = 1'b1, cfgComInv = 1'b0, cfgComSeq = 1'b0, cfgComLrRemap = 1'b0;
  logic cfgPumpNeed = 1'b1, cfgAreaColor = 1'b0, cfgLowPower = 1'b0, cfgLutEn = 1'b0;
  logic [31:0] cfgLut = '0;
  logic pwrReq = 1'b0, pwrOn = 1'b0, outReady = 1'b1;
  logic outValid, outStart, panelRstOut, lutWarn, initDone;
  logic [7:0] outData;

  int checks = 0;
  int errors = 0;
  int doneCount = 0;
  int cyc = 0;
  int readyMode = 0;
  bit finished = 0;
  logic [9:0] expQ[$];   // {warn, start, data}

  always #2 clk = ~clk;

  oled_init_seq #(.RST_ACTIVE_CYC(ACT), .RST_SETTLE_CYC(SET)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b, input bit warn);
    expQ.push_back({1'b0, 1'b1, 8'h80});
    expQ.push_back({warn, 1'b0, b});
  endtask

  task automatic buildExpected();
    pushByte(8'h81, 0); pushByte(cfgContrast, 0);                     // R3
    if (cfgSegRemap) pushByte(8'hA1, 0);                              // R4
    pushByte(8'hC0 + (cfgComInv ? 8'h08 : 8'h00), 0);
    pushByte(8'hA8, 0); pushByte(cfgHeight - 8'd1, 0);
    pushByte(8'hD3, 0); pushByte(cfgComOffset, 0);
    pushByte(8'hD5, 0); pushByte({cfgClkFrq, 4'(cfgClkDiv - 5'd1)}, 0);
    if (cfgAreaColor || cfgLowPower) begin                            // R5
      pushByte(8'hD8, 0);
      pushByte((cfgAreaColor ? 8'h30 : 8'h00) + (cfgLowPower ? 8'h05 : 8'h00), 0);
    end
    pushByte(8'hD9, 0); pushByte({cfgPre2, cfgPre1}, 0);              // R6
    pushByte(8'hDA, 0);
    pushByte(8'h02 + (cfgComSeq ? 8'h00 : 8'h10) + (cfgComLrRemap ? 8'h20 : 8'h00), 0);
    pushByte(8'hDB, 0); pushByte(cfgVcomh, 0);
    pushByte(8'h8D, 0); pushByte(cfgPumpNeed ? 8'h14 : 8'h10, 0);
    if (cfgLutEn) begin                                               // R7, R9
      pushByte(8'h91, 0);
      for (int i = 0; i < 4; i++) begin
        logic [7:0] e;
        e = cfgLut[i*8 +: 8];
        pushByte(e, (e < 8'd31) || (e > 8'd63));
      end
    end
    pushByte(8'h20, 0); pushByte(8'h00, 0); pushByte(8'hAF, 0);       // R8
  endtask

  // ready driver
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (readyMode)
      0: outReady = 1'b1;
      1: outReady = (cyc % 3) != 0;
      default: outReady = (cyc % 16) >= 11;
    endcase
  end

  // monitor / scoreboard
  logic       stallSeen = 1'b0;
  logic [8:0] stallVal;
  always @(negedge clk) begin
    if (rstN) begin
      if (stallSeen) begin
        check(outValid && {outStart, outData} == stallVal, "R10", "held byte",
              {outValid, outStart, outData}, {1'b1, stallVal});
      end
      stallSeen = outValid && !outReady;
      stallVal  = {outStart, outData};
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(0, "R12", "unexpected byte", {outStart, outData}, 0);
        end else begin
          logic [9:0] e;
          e = expQ.pop_front();
          check({lutWarn, outStart, outData} == e, e[8] ? "R1" : "R3", "stream item",
                {lutWarn, outStart, outData}, e);
        end
      end
      if (initDone) begin
        doneCount++;
        check(expQ.size() == 0, "R8", "queue empty at done", expQ.size(), 0);
      end
    end else begin
      stallSeen = 1'b0;
    end
  end

  task automatic runInit(input int mode, input bit earlyReq);
    int n;
    readyMode = mode;
    @(negedge clk);
    rstN = 1'b0;
    expQ.delete();
    doneCount = 0;
    buildExpected();
    repeat (4) @(negedge clk);
    check(!outValid && !initDone && panelRstOut, "R2", "reset state",
          {outValid, initDone, panelRstOut}, 3'b001);
    rstN = 1'b1;
    n = 0;
    while (panelRstOut && n < 10000) begin n++; @(negedge clk); end
    check(n == ACT, "R2", "reset pulse cycles", n, ACT);
    n = 0;
    while (!panelRstOut && !outValid && n < 10000) begin n++; @(negedge clk); end
    check(n == SET, "R2", "settle cycles", n, SET);
    if (earlyReq) begin                                               // R12
      pwrOn = 1'b0; pwrReq = 1'b1;
      @(negedge clk);
      pwrReq = 1'b0;
    end
    n = 0;
    while (doneCount == 0 && n < 20000) begin n++; @(negedge clk); end
    repeat (40) @(negedge clk);
    check(doneCount == 1, "R8", "done pulses", doneCount, 1);
    check(expQ.size() == 0, earlyReq ? "R12" : "R8", "leftover items", expQ.size(), 0);
  endtask

  task automatic runtimeReq(input bit on);
    @(negedge clk);
    pushByte(on ? 8'hAF : 8'hAE, 0);
    pwrOn = on; pwrReq = 1'b1;
    @(negedge clk);
    pwrReq = 1'b0;
    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R11", "runtime command sent", expQ.size(), 0);
    check(doneCount == 1, "R11", "no extra done", doneCount, 1);
  endtask

  initial begin
    // Scenario A: default-like values, remap on, pump on, no optional groups
    runInit(0, 0);
    runtimeReq(1'b0);
    runtimeReq(1'b1);

    // Scenario B: remap off, both area/low-power, table with out-of-range entries
    cfgSegRemap = 0; cfgComInv = 1; cfgComSeq = 1; cfgComLrRemap = 1;
    cfgPumpNeed = 0; cfgAreaColor = 1; cfgLowPower = 1; cfgLutEn = 1;
    cfgLut = {8'd63, 8'd64, 8'd31, 8'd20};
    cfgContrast = 8'hC3; cfgClkDiv = 5'd16; cfgClkFrq = 4'hF;
    cfgPre1 = 4'h1; cfgPre2 = 4'hF; cfgVcomh = 8'h34; cfgComOffset = 8'd5;
    runInit(1, 1);

    // Scenario C: low power only, tall panel, long stalls
    cfgSegRemap = 1; cfgComInv = 0; cfgAreaColor = 0; cfgLowPower = 1;
    cfgLutEn = 0; cfgHeight = 8'd64; cfgClkDiv = 5'd2; cfgClkFrq = 4'hC;
    runInit(2, 0);
    runtimeReq(1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule